// File: doc/BRIEF.md
# Parallel Rectifier Drive Fault Supervisor

This block watches the seven switching legs of a motor drive that is fed by two parallel single-phase rectifier bridges and a three-phase inverter. On every clock it receives a sampled reference pole voltage, a sampled measured pole voltage and the upper-switch gate command for each leg. For each leg it forms the absolute difference between reference and measurement. A hysteresis detector with a confirmation count turns that difference into a fault flag. At the moment a fault is confirmed, the flag is classified as an open-circuit or a short-circuit fault.

A configuration state machine reacts to the flags. A bridge with an open-circuit fault is switched off as a whole. A bridge with a shorted device is first forced fully on for a programmable number of cycles, so that its series fuses clear, and is then released to off. A failed inverter leg is replaced by leg b2 of the second bridge: the matching thyristor pair is enabled, the failed leg and leg b1 are held off, and a remap code tells the modulator which phase b2 now drives. Every post-fault configuration is latched. Any further fault outside the already isolated legs drives the block into a shutdown state with all gates off.

The states are CFG_HEALTHY (0), CFG_A_FUSE (1), CFG_A_ISO (2), CFG_B_FUSE (3), CFG_B_ISO (4), CFG_INV_REMAP (5) and CFG_SHUTDOWN (6).

The transitions from CFG_HEALTHY are:
- a fault in bridge A goes to CFG_A_FUSE if it is a short and to CFG_A_ISO if it is open;
- a fault in bridge B goes to CFG_B_FUSE or CFG_B_ISO in the same way;
- a fault in a single inverter leg goes to CFG_INV_REMAP;
- several faulted units at once go to CFG_SHUTDOWN.

From the fuse states, the block moves on to the matching isolation state once the hold time has elapsed. The fuse, isolation and remap states move to CFG_SHUTDOWN when a new fault appears. CFG_SHUTDOWN is left only through reset.

Top module: `cfr_supervisor`

## Requirements
- R1: Leg order on the buses is a1, a2 (bridge A), b1, b2 (bridge B), then inverter legs 0, 1, 2 in bits 4 to 6. A leg's `leg_fault` bit rises on the clock edge that samples the CONFIRM-th consecutive value of |vref - vmeas| strictly above `thr_hi`. A shorter run, interrupted by one sample at or below `thr_hi`, raises nothing.
- R2: A raised `leg_fault` bit stays high while the error is at or above `thr_lo`. It clears on the edge that samples an error strictly below `thr_lo`.
- R3: On confirmation, a fault is classed as short (`leg_short` bit = 1) when the gate command is 0 and the measured voltage is at or above full scale minus RAIL_BAND. Otherwise it is classed as open (bit = 0).
- R4: A single open fault in a bridge moves the block, one clock after the flag, to the isolation state for that bridge (A: 2, B: 4). That bridge's override then reads 01 (all off) and the other bridge's override reads 00 (pass).
- R5: A short fault in a bridge moves the block to its fuse state (A: 1, B: 3), where the override reads 10 (all on). The fuse state lasts max(`fuse_hold`, 1) cycles, after which the block enters the isolation state with override 01.
- R6: A fault on inverter leg k alone moves the block to state 5. In that state `scr_en` and `inv_leg_off` both equal 1<<k, `remap_sel` equals k+1 and `b1_isolate` is 1.
- R7: Post-fault states are latched. A clearing fault flag never returns the block to CFG_HEALTHY; only `rst_n` does.
- R8: In a post-fault state, flags on legs that state has already isolated are ignored. A flag on any other leg moves the block to CFG_SHUTDOWN: both overrides 01, `inv_leg_off` = 111, `scr_en` = 000, `remap_sel` = 0 and `shutdown` = 1. The block stays there until reset.
- R9: From CFG_HEALTHY, faults seen in the same cycle in more than one unit (bridge A, bridge B, inverter), or on more than one inverter leg, go straight to CFG_SHUTDOWN.
- R10: After reset the state is 0, both overrides are 00, all thyristor, remap, isolation, fault and shutdown outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vref_bus | input | 7*W | Reference pole voltage per leg, unsigned |
| vmeas_bus | input | 7*W | Measured pole voltage per leg, unsigned |
| gate_bus | input | 7 | Upper-switch gate command per leg |
| thr_hi | input | W | Upper hysteresis threshold |
| thr_lo | input | W | Lower hysteresis threshold |
| fuse_hold | input | HOLD_W | Fuse-clearing force-on duration in cycles |
| rect_a_ovr | output | 2 | Bridge A gate override: 00 pass, 01 off, 10 on |
| rect_b_ovr | output | 2 | Bridge B gate override, same coding |
| inv_leg_off | output | 3 | Per inverter leg: hold gates off |
| scr_en | output | 3 | Thyristor pair enable per inverter leg |
| remap_sel | output | 2 | 0 none, k+1 when leg b2 replaces inverter leg k |
| b1_isolate | output | 1 | Hold leg b1 gates off |
| leg_fault | output | 7 | Hysteresis fault flag per leg |
| leg_short | output | 7 | Fault class per leg, 1 for short |
| cfg_state | output | 3 | Current configuration state code |
| shutdown | output | 1 | Global shutdown active |

## Verification
Some properties are checked by assertions on every cycle:
- a flag rises only after an error above the upper threshold and falls only after one below the lower threshold;
- a post-fault state never returns to healthy, and shutdown is never left;
- a fuse state exits only to its own isolation state or to shutdown;
- at most one thyristor pair is enabled, and only together with the isolation of leg b1.

Other behaviour can only be shown by the directed scenarios:
- the exact confirmation count, and a run that is too short;
- the open and short classification;
- the duration of the force-on window;
- the choice of phase to remap;
- which later faults are ignored and which cause shutdown.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

    localparam int NLEG = 7;

    localparam logic [NLEG-1:0] MASK_A   = 7'b000_0011;
    localparam logic [NLEG-1:0] MASK_B   = 7'b000_1100;
    localparam logic [NLEG-1:0] MASK_INV = 7'b111_0000;
    localparam int LEG_B1   = 2;
    localparam int INV_BASE = 4;

    typedef enum logic [2:0] {
        CFG_HEALTHY   = 3'd0,
        CFG_A_FUSE    = 3'd1,
        CFG_A_ISO     = 3'd2,
        CFG_B_FUSE    = 3'd3,
        CFG_B_ISO     = 3'd4,
        CFG_INV_REMAP = 3'd5,
        CFG_SHUTDOWN  = 3'd6
    } cfg_state_t;

    typedef enum logic [1:0] {
        OVR_PASS = 2'b00,
        OVR_OFF  = 2'b01,
        OVR_ON   = 2'b10
    } ovr_t;

endpackage

// File: rtl/cfr_leg_monitor.sv
module cfr_leg_monitor #(
    parameter int W         = 12,
    parameter int CONFIRM   = 4,
    parameter int RAIL_BAND = 100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] vref,
    input  logic [W-1:0] vmeas,
    input  logic         gate,
    input  logic [W-1:0] thr_hi,
    input  logic [W-1:0] thr_lo,
    output logic         flag,
    output logic         is_short
);

    localparam int          CW      = $clog2(CONFIRM + 1);
    localparam logic [CW-1:0] LAST  = CW'(CONFIRM - 1);
    localparam logic [W-1:0]  HI_RAIL = W'((2 ** W) - 1 - RAIL_BAND);

    logic [W-1:0]  err;
    logic [CW-1:0] cnt;
    logic          at_top;

    always_comb begin
        err    = (vref > vmeas) ? (vref - vmeas) : (vmeas - vref);
        at_top = (vmeas >= HI_RAIL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag     <= 1'b0;
            is_short <= 1'b0;
            cnt      <= '0;
        end else if (!flag) begin
            if (err > thr_hi) begin
                if (cnt == LAST) begin
                    flag     <= 1'b1;
                    is_short <= !gate && at_top;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end else if (err < thr_lo) begin
            flag     <= 1'b0;
            is_short <= 1'b0;
        end
    end

    a_r1_rise_needs_high_err: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(err > thr_hi));

    a_r2_fall_needs_low_err: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(err < thr_lo));

endmodule

// File: rtl/cfr_reconfig_fsm.sv
module cfr_reconfig_fsm
    import cfr_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLEG-1:0]   leg_flag,
    input  logic [3:0]        rect_short,
    input  logic [HOLD_W-1:0] fuse_hold,
    output logic [1:0]        rect_a_ovr,
    output logic [1:0]        rect_b_ovr,
    output logic [2:0]        inv_leg_off,
    output logic [2:0]        scr_en,
    output logic [1:0]        remap_sel,
    output logic              b1_isolate,
    output logic [2:0]        cfg_state,
    output logic              shutdown
);

    cfg_state_t        state, nxt;
    logic [HOLD_W-1:0] hold_cnt;
    logic [1:0]        inv_sel, inv_idx;
    logic              a_f, b_f, i_any, a_s, b_s, hold_done;
    logic [2:0]        inv_f;
    logic [1:0]        n_units;
    logic [NLEG-1:0]   remap_keep;

    always_comb begin
        a_f     = |(leg_flag & MASK_A);
        b_f     = |(leg_flag & MASK_B);
        inv_f   = leg_flag[INV_BASE +: 3];
        i_any   = |inv_f;
        a_s     = |(leg_flag[1:0] & rect_short[1:0]);
        b_s     = |(leg_flag[3:2] & rect_short[3:2]);
        n_units = {1'b0, a_f} + {1'b0, b_f} + {1'b0, i_any};
        inv_idx = 2'd0;
        for (int k = 2; k >= 0; k--) begin
            if (inv_f[k]) inv_idx = 2'(k);
        end
        remap_keep = '0;
        remap_keep[LEG_B1] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            if (inv_sel == 2'(k)) remap_keep[INV_BASE + k] = 1'b1;
        end
        hold_done = ({1'b0, hold_cnt} + (HOLD_W+1)'(1)) >= {1'b0, fuse_hold};
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CFG_HEALTHY: begin
                if (n_units > 2'd1 || $countones(inv_f) > 1) nxt = CFG_SHUTDOWN;
                else if (a_f)   nxt = a_s ? CFG_A_FUSE : CFG_A_ISO;
                else if (b_f)   nxt = b_s ? CFG_B_FUSE : CFG_B_ISO;
                else if (i_any) nxt = CFG_INV_REMAP;
            end
            CFG_A_FUSE: begin
                if (|(leg_flag & ~MASK_A)) nxt = CFG_SHUTDOWN;
                else if (hold_done)        nxt = CFG_A_ISO;
            end
            CFG_A_ISO: begin
                if (|(leg_flag & ~MASK_A)) nxt = CFG_SHUTDOWN;
            end
            CFG_B_FUSE: begin
                if (|(leg_flag & ~MASK_B)) nxt = CFG_SHUTDOWN;
                else if (hold_done)        nxt = CFG_B_ISO;
            end
            CFG_B_ISO: begin
                if (|(leg_flag & ~MASK_B)) nxt = CFG_SHUTDOWN;
            end
            CFG_INV_REMAP: begin
                if (|(leg_flag & ~remap_keep)) nxt = CFG_SHUTDOWN;
            end
            CFG_SHUTDOWN: nxt = CFG_SHUTDOWN;
            default:      nxt = CFG_SHUTDOWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CFG_HEALTHY;
            hold_cnt <= '0;
            inv_sel  <= 2'd0;
        end else begin
            state <= nxt;
            if (nxt != state)  hold_cnt <= '0;
            else               hold_cnt <= hold_cnt + 1'b1;
            if (state == CFG_HEALTHY && nxt == CFG_INV_REMAP) inv_sel <= inv_idx;
        end
    end

    always_comb begin
        rect_a_ovr  = OVR_PASS;
        rect_b_ovr  = OVR_PASS;
        inv_leg_off = 3'b000;
        scr_en      = 3'b000;
        remap_sel   = 2'd0;
        b1_isolate  = 1'b0;
        shutdown    = 1'b0;
        unique case (state)
            CFG_HEALTHY: ;
            CFG_A_FUSE:  rect_a_ovr = OVR_ON;
            CFG_A_ISO:   rect_a_ovr = OVR_OFF;
            CFG_B_FUSE:  rect_b_ovr = OVR_ON;
            CFG_B_ISO:   rect_b_ovr = OVR_OFF;
            CFG_INV_REMAP: begin
                inv_leg_off = 3'b001 << inv_sel;
                scr_en      = 3'b001 << inv_sel;
                remap_sel   = inv_sel + 2'd1;
                b1_isolate  = 1'b1;
            end
            CFG_SHUTDOWN: begin
                rect_a_ovr  = OVR_OFF;
                rect_b_ovr  = OVR_OFF;
                inv_leg_off = 3'b111;
                shutdown    = 1'b1;
            end
            default: begin
                rect_a_ovr  = OVR_OFF;
                rect_b_ovr  = OVR_OFF;
                inv_leg_off = 3'b111;
                shutdown    = 1'b1;
            end
        endcase
        cfg_state = state;
    end

    a_r7_no_return_to_healthy: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CFG_HEALTHY) |=> (state != CFG_HEALTHY));

    a_r8_shutdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CFG_SHUTDOWN) |=> (state == CFG_SHUTDOWN));

    a_r5_a_fuse_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CFG_A_FUSE) |=> (state == CFG_A_FUSE || state == CFG_A_ISO || state == CFG_SHUTDOWN));

    a_r5_b_fuse_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CFG_B_FUSE) |=> (state == CFG_B_FUSE || state == CFG_B_ISO || state == CFG_SHUTDOWN));

endmodule

// File: rtl/cfr_supervisor.sv
module cfr_supervisor
    import cfr_pkg::*;
#(
    parameter int W         = 12,
    parameter int CONFIRM   = 4,
    parameter int RAIL_BAND = 100,
    parameter int HOLD_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLEG*W-1:0] vref_bus,
    input  logic [NLEG*W-1:0] vmeas_bus,
    input  logic [NLEG-1:0]   gate_bus,
    input  logic [W-1:0]      thr_hi,
    input  logic [W-1:0]      thr_lo,
    input  logic [HOLD_W-1:0] fuse_hold,
    output logic [1:0]        rect_a_ovr,
    output logic [1:0]        rect_b_ovr,
    output logic [2:0]        inv_leg_off,
    output logic [2:0]        scr_en,
    output logic [1:0]        remap_sel,
    output logic              b1_isolate,
    output logic [NLEG-1:0]   leg_fault,
    output logic [NLEG-1:0]   leg_short,
    output logic [2:0]        cfg_state,
    output logic              shutdown
);

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        cfr_leg_monitor #(
            .W(W), .CONFIRM(CONFIRM), .RAIL_BAND(RAIL_BAND)
        ) mon_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .vref     (vref_bus[g*W +: W]),
            .vmeas    (vmeas_bus[g*W +: W]),
            .gate     (gate_bus[g]),
            .thr_hi   (thr_hi),
            .thr_lo   (thr_lo),
            .flag     (leg_fault[g]),
            .is_short (leg_short[g])
        );
    end

    cfr_reconfig_fsm #(.HOLD_W(HOLD_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .leg_flag    (leg_fault),
        .rect_short  (leg_short[3:0]),
        .fuse_hold   (fuse_hold),
        .rect_a_ovr  (rect_a_ovr),
        .rect_b_ovr  (rect_b_ovr),
        .inv_leg_off (inv_leg_off),
        .scr_en      (scr_en),
        .remap_sel   (remap_sel),
        .b1_isolate  (b1_isolate),
        .cfg_state   (cfg_state),
        .shutdown    (shutdown)
    );

    a_r6_single_scr: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(scr_en));

    a_r6_scr_with_b1_iso: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_en != 3'b000) |-> (b1_isolate && remap_sel != 2'd0));

    a_r8_shutdown_no_force_on: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (rect_a_ovr == 2'b01 && rect_b_ovr == 2'b01 && scr_en == 3'b000));

endmodule

// File: tb/cfr_supervisor_tb_top.sv
module cfr_supervisor_tb_top;

    localparam int W = 12;
    localparam int N = 7;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N*W-1:0]  vref_bus, vmeas_bus;
    logic [N-1:0]    gate_bus;
    logic [W-1:0]    thr_hi, thr_lo;
    logic [7:0]      fuse_hold;
    logic [1:0]      rect_a_ovr, rect_b_ovr, remap_sel;
    logic [2:0]      inv_leg_off, scr_en, cfg_state;
    logic            b1_isolate, shutdown;
    logic [N-1:0]    leg_fault, leg_short;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cfr_supervisor dut_i (
        .clk(clk), .rst_n(rst_n), .vref_bus(vref_bus), .vmeas_bus(vmeas_bus),
        .gate_bus(gate_bus), .thr_hi(thr_hi), .thr_lo(thr_lo), .fuse_hold(fuse_hold),
        .rect_a_ovr(rect_a_ovr), .rect_b_ovr(rect_b_ovr), .inv_leg_off(inv_leg_off),
        .scr_en(scr_en), .remap_sel(remap_sel), .b1_isolate(b1_isolate),
        .leg_fault(leg_fault), .leg_short(leg_short), .cfg_state(cfg_state),
        .shutdown(shutdown)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_leg(input int i, input int vr, input int vm, input logic g);
        vref_bus[i*W +: W]  = W'(vr);
        vmeas_bus[i*W +: W] = W'(vm);
        gate_bus[i]         = g;
    endtask

    task automatic leg_ok(input int i);
        set_leg(i, 2048, 2048, 1'b0);
    endtask

    task automatic leg_open(input int i);
        set_leg(i, 4095, 0, 1'b1);
    endtask

    task automatic leg_short_f(input int i);
        set_leg(i, 0, 4095, 1'b0);
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input int hold);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < N; i++) leg_ok(i);
        thr_hi = 12'd200;
        thr_lo = 12'd50;
        fuse_hold = 8'(hold);
        ticks(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(5);
        ticks(3);
        chk("R10 state", 32'(cfg_state), 32'd0);
        chk("R10 ovr", 32'({rect_a_ovr, rect_b_ovr}), 32'd0);
        chk("R10 inv/scr/remap", 32'({inv_leg_off, scr_en, remap_sel, b1_isolate, shutdown}), 32'd0);
        chk("R10 flags", 32'({leg_fault, leg_short}), 32'd0);
    endtask

    task automatic t_hyst_remap();
        do_reset(5);
        set_leg(5, 2048, 2348, 1'b0);
        ticks(3);
        leg_ok(5);
        ticks(1);
        chk("R1 short run no flag", 32'(leg_fault), 32'd0);
        set_leg(5, 2048, 2348, 1'b0);
        ticks(3);
        chk("R1 flag not before count", 32'(leg_fault[5]), 32'd0);
        ticks(1);
        chk("R1 flag at count", 32'(leg_fault[5]), 32'd1);
        chk("R3 mid-level is open", 32'(leg_short[5]), 32'd0);
        chk("R1 state lags flag", 32'(cfg_state), 32'd0);
        ticks(1);
        chk("R6 state", 32'(cfg_state), 32'd5);
        chk("R6 scr", 32'(scr_en), 32'b010);
        chk("R6 inv off", 32'(inv_leg_off), 32'b010);
        chk("R6 remap", 32'(remap_sel), 32'd2);
        chk("R6 b1 iso", 32'(b1_isolate), 32'd1);
        set_leg(5, 2048, 2148, 1'b0);
        ticks(4);
        chk("R2 held between thresholds", 32'(leg_fault[5]), 32'd1);
        set_leg(5, 2048, 2088, 1'b0);
        ticks(1);
        chk("R2 cleared below low", 32'(leg_fault[5]), 32'd0);
        ticks(6);
        chk("R7 remap latched", 32'(cfg_state), 32'd5);
    endtask

    task automatic t_open_a();
        do_reset(5);
        leg_open(0);
        ticks(5);
        chk("R3 open class", 32'(leg_short[0]), 32'd0);
        chk("R4 A iso state", 32'(cfg_state), 32'd2);
        chk("R4 A off B pass", 32'({rect_a_ovr, rect_b_ovr}), 32'b0100);
        leg_ok(0);
        ticks(8);
        chk("R7 A iso latched", 32'(cfg_state), 32'd2);
        leg_open(1);
        ticks(7);
        chk("R8 isolated leg ignored", 32'(cfg_state), 32'd2);
        leg_open(3);
        ticks(5);
        chk("R8 second fault shutdown", 32'(cfg_state), 32'd6);
        chk("R8 shutdown outputs", 32'({rect_a_ovr, rect_b_ovr, inv_leg_off, scr_en, remap_sel, shutdown}),
            32'({2'b01, 2'b01, 3'b111, 3'b000, 2'b00, 1'b1}));
        for (int i = 0; i < N; i++) leg_ok(i);
        ticks(8);
        chk("R8 shutdown sticky", 32'(cfg_state), 32'd6);
    endtask

    task automatic t_short_b();
        do_reset(5);
        leg_short_f(3);
        ticks(5);
        chk("R3 short class", 32'(leg_short[3]), 32'd1);
        chk("R5 B fuse state", 32'(cfg_state), 32'd3);
        chk("R5 B force on", 32'({rect_a_ovr, rect_b_ovr}), 32'b0010);
        ticks(4);
        chk("R5 B still on at hold end", 32'(rect_b_ovr), 32'b10);
        ticks(1);
        chk("R5 B released off", 32'(rect_b_ovr), 32'b01);
        chk("R5 B iso state", 32'(cfg_state), 32'd4);
    endtask

    task automatic t_short_a_min();
        do_reset(0);
        leg_short_f(1);
        ticks(5);
        chk("R5 A one-cycle on", 32'(rect_a_ovr), 32'b10);
        ticks(1);
        chk("R5 A off after min hold", 32'(rect_a_ovr), 32'b01);
        chk("R5 A iso state", 32'(cfg_state), 32'd2);
    endtask

    task automatic t_open_b();
        do_reset(5);
        set_leg(2, 4000, 10, 1'b1);
        ticks(5);
        chk("R4 B iso state", 32'(cfg_state), 32'd4);
        chk("R4 B off A pass", 32'({rect_a_ovr, rect_b_ovr}), 32'b0001);
    endtask

    task automatic t_inv_second();
        do_reset(5);
        leg_open(6);
        ticks(5);
        chk("R6 leg2 remap", 32'({scr_en, remap_sel}), 32'({3'b100, 2'd3}));
        leg_open(2);
        leg_open(6);
        ticks(7);
        chk("R8 b1 fault ignored in remap", 32'(cfg_state), 32'd5);
        leg_open(0);
        ticks(5);
        chk("R8 bridge A fault in remap", 32'(cfg_state), 32'd6);
    endtask

    task automatic t_simul();
        do_reset(5);
        leg_open(0);
        leg_open(4);
        ticks(5);
        chk("R9 two units shutdown", 32'(cfg_state), 32'd6);
        do_reset(5);
        leg_open(4);
        leg_open(5);
        ticks(5);
        chk("R9 two inverter legs shutdown", 32'({cfg_state, shutdown}), 32'({3'd6, 1'b1}));
    endtask

    initial begin
        rst_n = 1'b0;
        vref_bus = '0;
        vmeas_bus = '0;
        gate_bus = '0;
        thr_hi = '0;
        thr_lo = '0;
        fuse_hold = '0;
        t_reset();
        t_hyst_remap();
        t_open_a();
        t_short_b();
        t_short_a_min();
        t_open_b();
        t_inv_second();
        t_simul();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule